// File: doc/BRIEF.md
# Receive FIFO Host Read Controller

This block sits between a receive data FIFO and the host read port. It hands the host one packet buffer at a time as 32-bit words. The FIFO marks the final word of each buffer. After that word, the block inserts zero-valued pad words until the number of words read for the buffer is a multiple of a programmable end alignment. The host knows the alignment and drops the padding. A pad flag on the host port marks each pad word. The FIFO is not popped for pad words.

A host-loaded word counter counts down by one for every word the host reads, data or pad. When a read brings it to zero, the counter raises a sticky interrupt. The host clears the interrupt by writing 1 to its clear strobe. The host may reload the counter at any moment, and the new value replaces whatever remains.

A discard command empties the receive data and status FIFOs. The command clears itself after one cycle. The flush pulse it produces also cancels any buffer in progress, including pending padding, inside the block.

Top module: `rxfifo_host_reader`

## Requirements
- R1: The 2-bit alignment code selects the pad boundary. Code 0 is 4 bytes (1 word), code 1 is 16 bytes (4 words) and code 2 is 32 bytes (8 words). Code 3 is reserved and behaves as code 0, so no padding is added. The stored code reads back on `align_q`.
- R2: After the host reads a word whose `fifo_last` is 1, the block presents `(N - L mod N) mod N` pad words, where L is the buffer length and N is the alignment in words. Each pad word has `host_pad`=1 and `host_data`=0, and pad reads do not pop the FIFO. No pad word follows once the count is met.
- R3: The alignment is captured when the first word of a buffer is read and applies to that whole buffer. An alignment written in the middle of a buffer takes effect from the next buffer.
- R4: Each accepted host read (`host_rd` while `host_valid`), data or pad, lowers `dma_count` by one. The count holds at zero.
- R5: When a read lowers `dma_count` from 1 to 0, `dma_irq` goes to 1 on the following cycle. It stays at 1 until an `irq_clr` pulse. A new set in the same cycle as a clear wins.
- R6: A `cnt_we` pulse loads `cnt_in` into `dma_count` on the next edge, taking priority over a decrement in the same cycle. Loading zero never raises `dma_irq`.
- R7: A `discard_req` pulse produces exactly one `fifo_flush` cycle on the following cycle. During that cycle `host_valid` is 0, and the buffer progress and pending padding are cleared. The next buffer starts its pad count from zero.
- R8: Synchronous active-low reset leaves `align_q`=0, `dma_count`=0, `dma_irq`=0 and `fifo_flush`=0, with no padding pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| align_we | input | 1 | Write strobe for the alignment code |
| align_in | input | 2 | Alignment code to store |
| align_q | output | 2 | Stored alignment code |
| cnt_we | input | 1 | Load strobe for the word counter |
| cnt_in | input | CNT_W (12) | Value to load into the word counter |
| dma_count | output | CNT_W (12) | Remaining word count |
| irq_clr | input | 1 | Write-1 clear of the interrupt |
| dma_irq | output | 1 | Sticky count-reached-zero interrupt |
| discard_req | input | 1 | Discard command pulse |
| fifo_flush | output | 1 | One-cycle flush to the data and status FIFOs |
| fifo_valid | input | 1 | FIFO holds a word |
| fifo_data | input | DATA_W (32) | FIFO head word |
| fifo_last | input | 1 | Head word ends its buffer |
| fifo_pop | output | 1 | Pop the FIFO head |
| host_rd | input | 1 | Host read strobe |
| host_valid | output | 1 | A word (data or pad) is available |
| host_data | output | DATA_W (32) | Word to the host |
| host_pad | output | 1 | Current word is padding |

## Verification
Every alignment code, including the reserved one, is swept against buffer lengths 1 through 9. Each pad count is computed arithmetically. A wrong word mask, a miscounted remainder or a missing reserved-code mapping then shows up as a wrong number of pad words, or as a pad word left over once the count is met. A separate pattern changes the alignment partway through a buffer, which tells a latched alignment apart from a live one. Countdown patterns cover:
- expiry on a data word and on a pad word,
- a reload in the middle of a count,
- a load of zero.

These separate the decrement, reload priority and spurious-interrupt cases. Discards issued mid-buffer and mid-padding show whether the pad phase is really cleared.

// File: rtl/rxr_pkg.sv
// Package: shared types and helpers for the receive FIFO host read controller.
// Assumes 32-bit host words, so the supported alignments are 1, 4 and 8 words.
package rxr_pkg;

    typedef enum logic [1:0] {
        ALIGN_4B   = 2'd0,
        ALIGN_16B  = 2'd1,
        ALIGN_32B  = 2'd2,
        ALIGN_RSVD = 2'd3
    } align_e;

    localparam int MAX_ALIGN_WORDS = 8;
    localparam int PHASE_W         = $clog2(MAX_ALIGN_WORDS);

    // Word-phase mask for an alignment; every alignment is a power of two in words.
    function automatic logic [PHASE_W-1:0] align_mask(input align_e a);
        case (a)
            ALIGN_16B: return PHASE_W'(3);
            ALIGN_32B: return PHASE_W'(7);
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/rxr_cfg_regs.sv
// Module: configuration holding for the read controller.
// Stores the alignment code and turns a discard request into a single
// registered flush cycle that clears itself.
// Assumes discard_req is a one-cycle write strobe.
module rxr_cfg_regs
    import rxr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   align_we,
    input  logic [1:0] align_in,
    input  logic   discard_req,
    output align_e align_q,
    output logic   discard_q
);

    // Alignment code register, written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)        align_q <= ALIGN_4B;
        else if (align_we) align_q <= align_e'(align_in);
    end

    // Self-clearing discard bit: high for one cycle per request.
    always_ff @(posedge clk) begin
        if (!rst_n) discard_q <= 1'b0;
        else        discard_q <= discard_req;
    end

endmodule

// File: rtl/rxr_pad_seq.sv
// Module: buffer framing and pad insertion.
// Passes FIFO words to the host. After the word marked last, it inserts
// zero pad words until the buffer length is a multiple of the alignment
// captured at the buffer's first word.
// Assumes fifo_data/fifo_last are stable while fifo_valid is 1 and no pop.
module rxr_pad_seq
    import rxr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  align_e            cfg_align,
    input  logic              flush,
    input  logic              fifo_valid,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic              fifo_last,
    output logic              fifo_pop,
    input  logic              host_rd,
    output logic              host_valid,
    output logic [DATA_W-1:0] host_data,
    output logic              host_pad,
    output logic              word_take
);

    logic [PHASE_W-1:0] phase;
    logic [PHASE_W-1:0] pad_left;
    logic               padding;
    logic               in_buf;
    align_e             buf_align;

    align_e             eff_align;
    logic [PHASE_W-1:0] eff_mask;
    logic [PHASE_W-1:0] phase_nxt;
    logic               data_take;

    // Alignment in force for the word now at the head.
    always_comb begin
        eff_align = in_buf ? buf_align : cfg_align;
        eff_mask  = align_mask(eff_align);
        phase_nxt = (phase + 1'b1) & eff_mask;
    end

    // Host-facing handshake and data selection.
    always_comb begin
        host_valid = !flush && (padding || fifo_valid);
        host_pad   = padding;
        host_data  = padding ? '0 : fifo_data;
        word_take  = host_rd && host_valid;
        data_take  = word_take && !padding;
        fifo_pop   = data_take;
    end

    // Buffer progress, alignment capture and pad countdown.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            phase     <= '0;
            pad_left  <= '0;
            padding   <= 1'b0;
            in_buf    <= 1'b0;
            buf_align <= ALIGN_4B;
        end else if (data_take) begin
            if (!in_buf) buf_align <= cfg_align;
            if (fifo_last) begin
                in_buf <= 1'b0;
                phase  <= '0;
                if (phase_nxt != '0) begin
                    padding  <= 1'b1;
                    pad_left <= eff_mask - phase_nxt + 1'b1;
                end
            end else begin
                in_buf <= 1'b1;
                phase  <= phase_nxt;
            end
        end else if (word_take && padding) begin
            pad_left <= pad_left - 1'b1;
            if (pad_left == PHASE_W'(1)) padding <= 1'b0;
        end
    end

endmodule

// File: rtl/rxr_dma_counter.sv
// Module: reloadable word countdown with a sticky interrupt.
// Decrements once per accepted host word and sets the interrupt only when a
// decrement reaches zero. A host load wins over a decrement and never sets
// the interrupt by itself.
module rxr_dma_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             word_take,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] count,
    output logic             irq
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic dec_ok;
    logic hit_zero;

    // Decide whether this cycle decrements, and whether that reaches zero.
    always_comb begin
        dec_ok   = word_take && !cnt_we && (count != '0);
        hit_zero = dec_ok && (count == ONE);
    end

    // Remaining word count.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (cnt_we) count <= cnt_in;
        else if (dec_ok) count <= count - ONE;
    end

    // Sticky interrupt; a set beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq <= 1'b0;
        else if (hit_zero) irq <= 1'b1;
        else if (irq_clr)  irq <= 1'b0;
    end

endmodule

// File: rtl/rxfifo_host_reader.sv
// Module: top of the receive FIFO host read controller.
// Joins the configuration holding, the pad sequencer and the word countdown.
// Assumes an external FIFO that shows its head word with a last-word flag and
// flushes both data and status storage on fifo_flush.
module rxfifo_host_reader
    import rxr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              align_we,
    input  logic [1:0]        align_in,
    output logic [1:0]        align_q,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_in,
    output logic [CNT_W-1:0]  dma_count,
    input  logic              irq_clr,
    output logic              dma_irq,
    input  logic              discard_req,
    output logic              fifo_flush,
    input  logic              fifo_valid,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic              fifo_last,
    output logic              fifo_pop,
    input  logic              host_rd,
    output logic              host_valid,
    output logic [DATA_W-1:0] host_data,
    output logic              host_pad
);

    align_e align_r;
    logic   discard_q;
    logic   word_take;

    rxr_cfg_regs u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .align_we    (align_we),
        .align_in    (align_in),
        .discard_req (discard_req),
        .align_q     (align_r),
        .discard_q   (discard_q)
    );

    rxr_pad_seq #(.DATA_W(DATA_W)) u_pad (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_align  (align_r),
        .flush      (discard_q),
        .fifo_valid (fifo_valid),
        .fifo_data  (fifo_data),
        .fifo_last  (fifo_last),
        .fifo_pop   (fifo_pop),
        .host_rd    (host_rd),
        .host_valid (host_valid),
        .host_data  (host_data),
        .host_pad   (host_pad),
        .word_take  (word_take)
    );

    rxr_dma_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_we    (cnt_we),
        .cnt_in    (cnt_in),
        .word_take (word_take),
        .irq_clr   (irq_clr),
        .count     (dma_count),
        .irq       (dma_irq)
    );

    // Expose stored code and flush strobe.
    always_comb begin
        align_q    = align_r;
        fifo_flush = discard_q;
    end

endmodule

// File: rtl/rxfifo_host_reader_chk.sv
// Module: property checker for rxfifo_host_reader, attached with bind.
module rxfifo_host_reader_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              align_we,
    input logic [1:0]        align_in,
    input logic [1:0]        align_q,
    input logic              cnt_we,
    input logic [CNT_W-1:0]  cnt_in,
    input logic [CNT_W-1:0]  dma_count,
    input logic              irq_clr,
    input logic              dma_irq,
    input logic              discard_req,
    input logic              fifo_flush,
    input logic              fifo_valid,
    input logic [DATA_W-1:0] fifo_data,
    input logic              fifo_last,
    input logic              fifo_pop,
    input logic              host_rd,
    input logic              host_valid,
    input logic [DATA_W-1:0] host_data,
    input logic              host_pad
);

    p_pad_nopop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_pad |-> !fifo_pop);

    p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_pad) |-> (host_data == '0));

    p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_valid && !cnt_we && dma_count != '0)
        |=> (dma_count == $past(dma_count) - 1'b1));

    p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_irq) |-> ($past(dma_count) == CNT_W'(1) && dma_count == '0));

    p_irq_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_irq && !irq_clr) |=> dma_irq);

    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (dma_count == $past(cnt_in)));

    p_zero_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && cnt_in == '0 && !dma_irq) |=> !dma_irq);

    p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        discard_req |=> fifo_flush);

    p_flush_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |-> (!host_valid && !fifo_pop));

endmodule

bind rxfifo_host_reader rxfifo_host_reader_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (.*);

// File: tb/test_rxfifo_host_reader.sv
module test_rxfifo_host_reader;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 32;
    localparam int CNT_W      = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              align_we = 1'b0;
    logic [1:0]        align_in = '0;
    logic [1:0]        align_q;
    logic              cnt_we = 1'b0;
    logic [CNT_W-1:0]  cnt_in = '0;
    logic [CNT_W-1:0]  dma_count;
    logic              irq_clr = 1'b0;
    logic              dma_irq;
    logic              discard_req = 1'b0;
    logic              fifo_flush;
    logic              fifo_valid;
    logic [DATA_W-1:0] fifo_data;
    logic              fifo_last;
    logic              fifo_pop;
    logic              host_rd = 1'b0;
    logic              host_valid;
    logic [DATA_W-1:0] host_data;
    logic              host_pad;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Simple FIFO model fed by the bench.
    logic [DATA_W-1:0] mem   [512];
    logic              lastm [512];
    logic [8:0]        wr_idx = '0;
    logic [8:0]        rd_idx = '0;
    int                seq = 0;
    int                exp_seq = 0;

    assign fifo_valid = (rd_idx != wr_idx);
    assign fifo_data  = mem[rd_idx];
    assign fifo_last  = lastm[rd_idx];

    always @(posedge clk) begin
        if (fifo_flush)    rd_idx <= wr_idx;
        else if (fifo_pop) rd_idx <= rd_idx + 1'b1;
    end

    always #(CLK_PERIOD/2) clk = ~clk;

    rxfifo_host_reader #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_rxfifo_host_reader (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int words_of(input int code);
        case (code)
            1: return 4;
            2: return 8;
            default: return 1;
        endcase
    endfunction

    task automatic push_buf(input int len);
        for (int i = 0; i < len; i++) begin
            mem[wr_idx]   = 32'hC0DE_0000 + 32'(seq);
            lastm[wr_idx] = (i == len - 1);
            wr_idx        = wr_idx + 1'b1;
            seq++;
        end
    endtask

    task automatic pulse_read();
        host_rd = 1'b1;
        @(posedge clk);
        #1 host_rd = 1'b0;
    endtask

    task automatic read_data(input string req);
        @(negedge clk);
        check(host_valid && !host_pad, req, {host_valid, host_pad}, 32'h2);
        check(host_data == 32'hC0DE_0000 + 32'(exp_seq), req, host_data, 32'hC0DE_0000 + 32'(exp_seq));
        exp_seq++;
        pulse_read();
    endtask

    task automatic read_pad(input string req);
        @(negedge clk);
        check(host_valid && host_pad && host_data == '0, req, {host_valid, host_pad, host_data[29:0]}, 32'hC000_0000);
        pulse_read();
    endtask

    task automatic expect_idle(input string req);
        @(negedge clk);
        check(!host_valid, req, host_valid, 0);
    endtask

    task automatic write_align(input int code);
        @(negedge clk);
        align_we = 1'b1; align_in = 2'(code);
        @(posedge clk);
        #1 align_we = 1'b0;
    endtask

    task automatic load_cnt(input int v);
        @(negedge clk);
        cnt_we = 1'b1; cnt_in = CNT_W'(v);
        @(posedge clk);
        #1 cnt_we = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk);
        irq_clr = 1'b1;
        @(posedge clk);
        #1 irq_clr = 1'b0;
    endtask

    task automatic do_discard();
        @(negedge clk);
        discard_req = 1'b1;
        @(posedge clk);
        #1 discard_req = 1'b0;
        @(negedge clk);
        check(fifo_flush == 1'b1, "R7 flush pulse", fifo_flush, 1);
        check(!host_valid, "R7 host blocked during flush", host_valid, 0);
        @(negedge clk);
        check(fifo_flush == 1'b0, "R7 flush self-clears", fifo_flush, 0);
        check(!host_valid, "R7 empty after flush", host_valid, 0);
        exp_seq = seq;
    endtask

    task automatic run_buf(input int code, input int len);
        int n;
        int pads;
        n    = words_of(code);
        pads = (n - (len % n)) % n;
        write_align(code);
        push_buf(len);
        for (int i = 0; i < len; i++) read_data("R1 data word");
        for (int i = 0; i < pads; i++) read_pad("R2 pad word");
        expect_idle("R2 no extra pad");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check(align_q == 2'd0, "R8 align reset", align_q, 0);
        check(dma_count == '0, "R8 count reset", dma_count, 0);
        check(!dma_irq, "R8 irq reset", dma_irq, 0);
        check(!fifo_flush, "R8 flush reset", fifo_flush, 0);
        check(!host_valid && !host_pad, "R8 no padding", {host_valid, host_pad}, 0);

        // R1/R2 sweep: every code x lengths 1..9
        for (int code = 0; code < 4; code++) begin
            write_align(code);
            @(negedge clk);
            check(align_q == 2'(code), "R1 align readback", align_q, code);
            for (int len = 1; len <= 9; len++) run_buf(code, len);
        end

        // R3: change alignment in the middle of a buffer
        write_align(2);
        push_buf(3);
        read_data("R3 first word");
        write_align(0);
        read_data("R3 mid word");
        read_data("R3 last word");
        for (int i = 0; i < 5; i++) read_pad("R3 pads from latched 32B");
        expect_idle("R3 pad count latched");
        push_buf(3);
        for (int i = 0; i < 3; i++) read_data("R3 next buffer data");
        expect_idle("R3 new alignment applies next buffer");

        // R4/R5: expiry on a data word
        load_cnt(5);
        @(negedge clk);
        check(dma_count == 12'd5, "R6 load", dma_count, 5);
        push_buf(5);
        for (int i = 0; i < 4; i++) read_data("R4 counted word");
        @(negedge clk);
        check(dma_count == 12'd1 && !dma_irq, "R4 decrement", {dma_irq, dma_count}, 1);
        read_data("R4 final word");
        @(negedge clk);
        check(dma_count == '0 && dma_irq, "R5 irq at zero", {dma_irq, dma_count}, 32'h1000);

        // R5: sticky, then clear
        clear_irq();
        @(negedge clk);
        check(!dma_irq, "R5 irq clear", dma_irq, 0);

        // R4/R5: expiry on a pad word, hold at zero
        write_align(1);
        load_cnt(3);
        push_buf(2);
        read_data("R4 data");
        read_data("R4 data");
        read_pad("R4 pad counts");
        @(negedge clk);
        check(dma_count == '0 && dma_irq, "R5 irq on pad word", {dma_irq, dma_count}, 32'h1000);
        read_pad("R4 pad at zero");
        @(negedge clk);
        check(dma_count == '0, "R4 holds at zero", dma_count, 0);
        clear_irq();

        // R6: loading zero never raises irq
        load_cnt(0);
        @(negedge clk);
        check(!dma_irq && dma_count == '0, "R6 zero load no irq", {dma_irq, dma_count}, 0);

        // R6: reload in the middle of a count
        write_align(0);
        load_cnt(10);
        push_buf(4);
        read_data("R6 data");
        read_data("R6 data");
        @(negedge clk);
        check(dma_count == 12'd8, "R4 count before reload", dma_count, 8);
        load_cnt(2);
        @(negedge clk);
        check(dma_count == 12'd2 && !dma_irq, "R6 reload replaces", {dma_irq, dma_count}, 2);
        read_data("R6 data");
        read_data("R6 data");
        @(negedge clk);
        check(dma_count == '0 && dma_irq, "R6 reloaded count expires", {dma_irq, dma_count}, 32'h1000);
        clear_irq();

        // R6: load wins over simultaneous decrement
        load_cnt(7);
        push_buf(1);
        @(negedge clk);
        cnt_we = 1'b1; cnt_in = 12'd4; host_rd = 1'b1;
        @(posedge clk);
        #1 cnt_we = 1'b0; host_rd = 1'b0;
        exp_seq++;
        @(negedge clk);
        check(dma_count == 12'd4, "R6 load priority", dma_count, 4);

        // R7: discard mid-buffer, pad phase restarts
        write_align(1);
        push_buf(3);
        read_data("R7 word before discard");
        do_discard();
        push_buf(2);
        read_data("R7 fresh buffer");
        read_data("R7 fresh buffer");
        read_pad("R7 pad after discard");
        read_pad("R7 pad after discard");
        expect_idle("R7 phase reset");

        // R7: discard while padding
        write_align(2);
        push_buf(1);
        read_data("R7 single word");
        read_pad("R7 pad");
        read_pad("R7 pad");
        do_discard();
        expect_idle("R7 padding cancelled");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule